// File: doc/BRIEF.md
# Accelerator Function Control and Status Registers

This block is the 64-bit register front end of a data-mover accelerator function. Software steers a global function state machine by writing a two-bit command code into a control register. It then observes the result in a status register. A command only requests a transition, and the machine accepts it only when the current state allows it. Stopping is staged. A soft stop enters a soft-stopping state, which can be escalated to hard stopping. Either stopping state falls to stopped a fixed number of cycles after the data path reports that its outstanding work has drained. An internal fault report forces the error state, and only a reset command leaves it.

Next to the state machine sit two read-only capability registers and a read-only version register, all set by parameters. There is also a limits register. Software writes its chosen limits there, and the block clamps each field to the matching capability. The doorbell stride implied by the capability register is also driven as a port, for a neighbouring doorbell decoder. Register access is a plain single-cycle port. Writes take effect at the clock edge, and read data is a combinational function of the address.

Top module: `accel_fn_regs`

## Requirements
- R1: After reset the state field reads 0 (stopped), and the command register and the limits register both read 0.
- R2: Status (offset 0x100) holds the state in bits [2:0] with 0 stopped, 1 initializing, 2 active, 3 soft stopping, 4 hard stopping, 5 error; its other bits read 0. Control 0 (offset 0x000) keeps the last written command field in bits [1:0] (0 reset, 1 soft stop, 2 hard stop, 3 activate) and reads 0 elsewhere.
- R3: Activate is accepted only in stopped: the state reads initializing after that write edge and active exactly INIT_CYCLES edges later; activate in any other state has no effect.
- R4: Soft stop moves initializing or active to soft stopping; hard stop moves soft stopping to hard stopping; either command in any other state has no effect, as does reset outside the error state.
- R5: A stopping state reads stopped after DRAIN_CYCLES edges, counting as the first the first edge that samples work_drained high in that state; drained need not stay high; entering hard stopping restarts the wait, which then needs a new drained indication.
- R6: fn_fault high at an edge moves every state except stopped and error to error, taking priority over any command or timed transition at that edge; in stopped it has no effect.
- R7: In error, the reset command moves the function to stopped; the other three commands have no effect.
- R8: When a timed transition (initializing to active, or stopping to stopped) completes at the same edge as a command write, the timed transition takes effect and the command is dropped.
- R9: A write to limits (offset 0x010) stores min(written, capability) for max buffer [3:0], max key size [15:12] and max context [31:16], stores written AND capability for the operation-group mask [63:32], and stores 0 in bits [11:4].
- R10: Capability 1 (offset 0x208) reads max buffer in [3:0], max key size in [15:12], max context in [31:16] and the operation-group mask in [63:32], other bits 0.
- R11: Capability 0 (offset 0x200) reads sub-function in [15:0], doorbell stride exponent in [22:20] and maximum ring size in [28:24], other bits 0; db_stride_bytes equals 4096 shifted left by the exponent.
- R12: Version (offset 0x210) reads major 1 in [23:16] and minor 0 in [7:0], other bits 0.
- R13: Writes to status, capability, version or unmapped addresses change no register and no state; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register accessed |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| work_drained | input | 1 | Data path reports that outstanding work has drained |
| fn_fault | input | 1 | Internal fault report forcing the error state |
| db_stride_bytes | output | 32 | Doorbell stride in bytes |

## Verification
The interesting collisions are between a software command write and a transition the machine takes on its own. One case is the last edge of the drain wait in soft stopping meeting a hard-stop write. Another is the initializing timer expiring under a soft-stop write. A third is a fault arriving together with a legal command. The bench counts edges from the drained pulse, or from the activate write, so that the write lands on the completing edge. It then checks that the timed or faulting outcome is read back from the status register and that the command is not.

// File: rtl/accel_fn_pkg.sv
package accel_fn_pkg;

   localparam int REG_W = 64;

   typedef enum logic [2:0] {
      FN_STOPPED   = 3'd0,
      FN_INIT      = 3'd1,
      FN_ACTIVE    = 3'd2,
      FN_SOFT_STOP = 3'd3,
      FN_HARD_STOP = 3'd4,
      FN_ERROR     = 3'd5
   } fn_state_e;

   typedef enum logic [1:0] {
      CMD_RESET    = 2'd0,
      CMD_SOFT     = 2'd1,
      CMD_HARD     = 2'd2,
      CMD_ACTIVATE = 2'd3
   } fn_cmd_e;

   // register byte offsets
   localparam logic [11:0] OFS_CTL0 = 12'h000;
   localparam logic [11:0] OFS_LIM  = 12'h010;
   localparam logic [11:0] OFS_STS  = 12'h100;
   localparam logic [11:0] OFS_CAP0 = 12'h200;
   localparam logic [11:0] OFS_CAP1 = 12'h208;
   localparam logic [11:0] OFS_VER  = 12'h210;

   // limit / capability-1 field layout
   localparam int LIM_NUM_FIELDS = 3;
   localparam int LIM_BUF_LO = 0;
   localparam int LIM_BUF_W  = 4;
   localparam int LIM_KEY_LO = 12;
   localparam int LIM_KEY_W  = 4;
   localparam int LIM_CTX_LO = 16;
   localparam int LIM_CTX_W  = 16;
   localparam int LIM_OPG_LO = 32;
   localparam int LIM_OPG_W  = 32;

   // capability-0 field layout
   localparam int CAP0_SUB_LO  = 0;
   localparam int CAP0_DBX_LO  = 20;
   localparam int CAP0_RING_LO = 24;

   // version field layout
   localparam int VER_MINOR_LO = 0;
   localparam int VER_MAJOR_LO = 16;

   localparam int DB_BASE_BYTES = 4096;

   function automatic int lim_lo(input int idx);
      case (idx)
         0:       return LIM_BUF_LO;
         1:       return LIM_KEY_LO;
         default: return LIM_CTX_LO;
      endcase
   endfunction

   function automatic int lim_w(input int idx);
      case (idx)
         0:       return LIM_BUF_W;
         1:       return LIM_KEY_W;
         default: return LIM_CTX_W;
      endcase
   endfunction

endpackage

// File: rtl/accel_fn_fsm.sv
module accel_fn_fsm
   import accel_fn_pkg::*;
#(
   parameter int INIT_CYCLES  = 4,
   parameter int DRAIN_CYCLES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_vld,
   input  logic [1:0] cmd_code,
   input  logic       fault,
   input  logic       drained,
   output fn_state_e  state
);

   localparam int CNT_MAX = (INIT_CYCLES > DRAIN_CYCLES) ? INIT_CYCLES : DRAIN_CYCLES;
   localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_CYCLES - 1);
   localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYCLES - 1);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("accel_fn_fsm: INIT_CYCLES must be at least 1");
   end
   if (DRAIN_CYCLES < 1) begin : g_bad_drain
      $error("accel_fn_fsm: DRAIN_CYCLES must be at least 1");
   end

   fn_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             armed_q, armed_d;

   logic      stopping, drain_go, drain_done, init_done;
   logic      cmd_ok;
   fn_state_e cmd_target;

   assign stopping   = (state_q == FN_SOFT_STOP) || (state_q == FN_HARD_STOP);
   assign drain_go   = stopping && (armed_q || drained);
   assign drain_done = drain_go && (cnt_q == DRAIN_LAST);
   assign init_done  = (state_q == FN_INIT) && (cnt_q == INIT_LAST);

   // which commands each state accepts
   always_comb begin
      cmd_ok     = 1'b0;
      cmd_target = state_q;
      case (state_q)
         FN_STOPPED: if (fn_cmd_e'(cmd_code) == CMD_ACTIVATE) begin
            cmd_ok = 1'b1; cmd_target = FN_INIT;
         end
         FN_INIT, FN_ACTIVE: if (fn_cmd_e'(cmd_code) == CMD_SOFT) begin
            cmd_ok = 1'b1; cmd_target = FN_SOFT_STOP;
         end
         FN_SOFT_STOP: if (fn_cmd_e'(cmd_code) == CMD_HARD) begin
            cmd_ok = 1'b1; cmd_target = FN_HARD_STOP;
         end
         FN_ERROR: if (fn_cmd_e'(cmd_code) == CMD_RESET) begin
            cmd_ok = 1'b1; cmd_target = FN_STOPPED;
         end
         default: ;
      endcase
   end

   // priority: fault, then timed completion, then command
   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      armed_d = armed_q;
      if (fault && (state_q != FN_STOPPED) && (state_q != FN_ERROR)) begin
         state_d = FN_ERROR;
         cnt_d   = '0;
         armed_d = 1'b0;
      end else if (init_done) begin
         state_d = FN_ACTIVE;
         cnt_d   = '0;
      end else if (drain_done) begin
         state_d = FN_STOPPED;
         cnt_d   = '0;
         armed_d = 1'b0;
      end else if (cmd_vld && cmd_ok) begin
         state_d = cmd_target;
         cnt_d   = '0;
         armed_d = 1'b0;
      end else if (state_q == FN_INIT) begin
         cnt_d = cnt_q + CNT_W'(1);
      end else if (drain_go) begin
         cnt_d   = cnt_q + CNT_W'(1);
         armed_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FN_STOPPED;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         armed_q <= armed_d;
      end
   end

   assign state = state_q;

endmodule

// File: rtl/accel_fn_limits.sv
module accel_fn_limits
   import accel_fn_pkg::*;
#(
   parameter logic [REG_W-1:0] CAP1_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] limits
);

   logic [REG_W-1:0] lim_d, lim_q;

   // numeric limits clamp to the capability value
   for (genvar gi = 0; gi < LIM_NUM_FIELDS; gi++) begin : g_num
      localparam int LO = lim_lo(gi);
      localparam int W  = lim_w(gi);
      assign lim_d[LO +: W] = (wdata[LO +: W] > CAP1_VAL[LO +: W]) ?
                              CAP1_VAL[LO +: W] : wdata[LO +: W];
   end

   // a support mask clamps by intersection
   assign lim_d[LIM_OPG_LO +: LIM_OPG_W] = wdata[LIM_OPG_LO +: LIM_OPG_W] &
                                           CAP1_VAL[LIM_OPG_LO +: LIM_OPG_W];
   assign lim_d[LIM_KEY_LO-1 : LIM_BUF_LO+LIM_BUF_W] = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lim_q <= '0;
      else if (wr_en) lim_q <= lim_d;
   end

   assign limits = lim_q;

endmodule

// File: rtl/accel_fn_rdmux.sv
module accel_fn_rdmux
   import accel_fn_pkg::*;
#(
   parameter int               ADDR_W   = 12,
   parameter bit               REG_READ = 1'b0,
   parameter logic [REG_W-1:0] CAP0_VAL = '0,
   parameter logic [REG_W-1:0] CAP1_VAL = '0,
   parameter logic [REG_W-1:0] VER_VAL  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        cmd_field,
   input  fn_state_e         state,
   input  logic [REG_W-1:0]  limits,
   output logic [REG_W-1:0]  rdata
);

   logic [REG_W-1:0] mux;

   always_comb begin
      mux = '0;
      case (addr)
         ADDR_W'(OFS_CTL0): mux = {{(REG_W-2){1'b0}}, cmd_field};
         ADDR_W'(OFS_LIM):  mux = limits;
         ADDR_W'(OFS_STS):  mux = {{(REG_W-3){1'b0}}, state};
         ADDR_W'(OFS_CAP0): mux = CAP0_VAL;
         ADDR_W'(OFS_CAP1): mux = CAP1_VAL;
         ADDR_W'(OFS_VER):  mux = VER_VAL;
         default:           mux = '0;
      endcase
   end

   if (REG_READ) begin : g_flop
      logic [REG_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= mux;
      end
      assign rdata = rd_q;
   end else begin : g_comb
      assign rdata = mux;
   end

endmodule

// File: rtl/accel_fn_regs.sv
module accel_fn_regs
   import accel_fn_pkg::*;
#(
   parameter int          ADDR_W       = 12,
   parameter int          INIT_CYCLES  = 4,
   parameter int          DRAIN_CYCLES = 3,
   parameter bit          REG_READ     = 1'b0,
   parameter logic [15:0] CAP_SUBFN    = 16'h0001,
   parameter logic [2:0]  CAP_DB_EXP   = 3'd0,
   parameter logic [4:0]  CAP_RING     = 5'd16,
   parameter logic [3:0]  CAP_MAX_BUF  = 4'd8,
   parameter logic [3:0]  CAP_MAX_KEY  = 4'd4,
   parameter logic [15:0] CAP_MAX_CTX  = 16'h00FF,
   parameter logic [31:0] CAP_OPG_MASK = 32'h0000_000F,
   parameter logic [7:0]  VER_MAJOR    = 8'd1,
   parameter logic [7:0]  VER_MINOR    = 8'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic              work_drained,
   input  logic              fn_fault,
   output logic [31:0]       db_stride_bytes
);

   if (ADDR_W < 10) begin : g_bad_addr
      $error("accel_fn_regs: ADDR_W too small for the register map");
   end

   localparam logic [REG_W-1:0] CAP0_VAL =
      (64'(CAP_SUBFN)  << CAP0_SUB_LO) |
      (64'(CAP_DB_EXP) << CAP0_DBX_LO) |
      (64'(CAP_RING)   << CAP0_RING_LO);
   localparam logic [REG_W-1:0] CAP1_VAL =
      (64'(CAP_MAX_BUF)  << LIM_BUF_LO) |
      (64'(CAP_MAX_KEY)  << LIM_KEY_LO) |
      (64'(CAP_MAX_CTX)  << LIM_CTX_LO) |
      (64'(CAP_OPG_MASK) << LIM_OPG_LO);
   localparam logic [REG_W-1:0] VER_VAL =
      (64'(VER_MAJOR) << VER_MAJOR_LO) | (64'(VER_MINOR) << VER_MINOR_LO);
   localparam logic [31:0] STRIDE_BYTES = 32'(DB_BASE_BYTES) << CAP_DB_EXP;

   logic       wr_ctl0, wr_lim;
   logic [1:0] cmd_q;
   fn_state_e  fn_state;
   logic [REG_W-1:0] ctl2_q;

   assign wr_ctl0 = reg_we && (reg_addr == ADDR_W'(OFS_CTL0));
   assign wr_lim  = reg_we && (reg_addr == ADDR_W'(OFS_LIM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cmd_q <= 2'd0;
      else if (wr_ctl0) cmd_q <= reg_wdata[1:0];
   end

   accel_fn_fsm #(
      .INIT_CYCLES  (INIT_CYCLES),
      .DRAIN_CYCLES (DRAIN_CYCLES)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_vld  (wr_ctl0),
      .cmd_code (reg_wdata[1:0]),
      .fault    (fn_fault),
      .drained  (work_drained),
      .state    (fn_state)
   );

   accel_fn_limits #(
      .CAP1_VAL (CAP1_VAL)
   ) u_lim (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_lim),
      .wdata  (reg_wdata),
      .limits (ctl2_q)
   );

   accel_fn_rdmux #(
      .ADDR_W   (ADDR_W),
      .REG_READ (REG_READ),
      .CAP0_VAL (CAP0_VAL),
      .CAP1_VAL (CAP1_VAL),
      .VER_VAL  (VER_VAL)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (reg_addr),
      .cmd_field (cmd_q),
      .state     (fn_state),
      .limits    (ctl2_q),
      .rdata     (reg_rdata)
   );

   assign db_stride_bytes = STRIDE_BYTES;

endmodule

// File: rtl/accel_fn_regs_chk.sv
module accel_fn_regs_chk #(
   parameter logic [3:0]  CAP_MAX_BUF  = 4'd8,
   parameter logic [3:0]  CAP_MAX_KEY  = 4'd4,
   parameter logic [15:0] CAP_MAX_CTX  = 16'h00FF,
   parameter logic [31:0] CAP_OPG_MASK = 32'h0000_000F
) (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  fn_state,
   input logic [63:0] ctl2_val,
   input logic        fn_fault
);

   assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fn_state <= 3'd5);

   assert_init_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_state == 3'd1 && $past(fn_state) != 3'd1) |-> $past(fn_state) == 3'd0);

   assert_soft_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_state == 3'd3 && $past(fn_state) != 3'd3) |->
      ($past(fn_state) == 3'd1 || $past(fn_state) == 3'd2));

   assert_hard_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_state == 3'd4 && $past(fn_state) != 3'd4) |-> $past(fn_state) == 3'd3);

   assert_error_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_state == 3'd5 && $past(fn_state) != 3'd5) |-> $past(fn_fault));

   assert_error_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fn_state) == 3'd5 && fn_state != 3'd5) |-> fn_state == 3'd0);

   assert_limits_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl2_val[3:0] <= CAP_MAX_BUF) && (ctl2_val[15:12] <= CAP_MAX_KEY) &&
      (ctl2_val[31:16] <= CAP_MAX_CTX) &&
      ((ctl2_val[63:32] & ~CAP_OPG_MASK) == 32'd0) && (ctl2_val[11:4] == 8'd0));

endmodule

bind accel_fn_regs accel_fn_regs_chk #(
   .CAP_MAX_BUF  (CAP_MAX_BUF),
   .CAP_MAX_KEY  (CAP_MAX_KEY),
   .CAP_MAX_CTX  (CAP_MAX_CTX),
   .CAP_OPG_MASK (CAP_OPG_MASK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fn_state (fn_state),
   .ctl2_val (ctl2_q),
   .fn_fault (fn_fault)
);

// File: tb/accel_fn_regs_test.sv
module accel_fn_regs_test;

   localparam int          INIT_N = 4;
   localparam int          DRAIN_N = 3;
   localparam logic [15:0] SUBFN = 16'h0A5C;
   localparam logic [2:0]  DBX   = 3'd3;
   localparam logic [4:0]  RING  = 5'd18;
   localparam logic [3:0]  MBUF  = 4'd9;
   localparam logic [3:0]  MKEY  = 4'd5;
   localparam logic [15:0] MCTX  = 16'h00FF;
   localparam logic [31:0] MOPG  = 32'h0000_F0F3;

   localparam logic [11:0] A_CTL0 = 12'h000, A_LIM = 12'h010, A_STS = 12'h100;
   localparam logic [11:0] A_CAP0 = 12'h200, A_CAP1 = 12'h208, A_VER = 12'h210;

   localparam int S_STOP = 0, S_INIT = 1, S_ACT = 2, S_SOFT = 3, S_HARD = 4, S_ERR = 5;
   localparam logic [63:0] C_RST = 64'd0, C_SOFT = 64'd1, C_HARD = 64'd2, C_ACT = 64'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        work_drained = 1'b0;
   logic        fn_fault = 1'b0;
   logic [31:0] db_stride_bytes;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   accel_fn_regs #(
      .ADDR_W(12), .INIT_CYCLES(INIT_N), .DRAIN_CYCLES(DRAIN_N), .REG_READ(1'b0),
      .CAP_SUBFN(SUBFN), .CAP_DB_EXP(DBX), .CAP_RING(RING), .CAP_MAX_BUF(MBUF),
      .CAP_MAX_KEY(MKEY), .CAP_MAX_CTX(MCTX), .CAP_OPG_MASK(MOPG),
      .VER_MAJOR(8'd1), .VER_MINOR(8'd0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .work_drained(work_drained),
      .fn_fault(fn_fault), .db_stride_bytes(db_stride_bytes)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [11:0] a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic f = 1'b0);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      fn_fault  = f;
      @(negedge clk);
      reg_we    = 1'b0;
      fn_fault  = 1'b0;
   endtask

   task automatic state_is(input string req, input int code);
      logic [63:0] d;
      peek(A_STS, d);
      chk(req, d, 64'(code));
   endtask

   task automatic go_active();
      wr(A_CTL0, C_ACT);
      tick(INIT_N);
   endtask

   // one drained pulse, then check each edge until stopped
   task automatic drain_sweep(input string req, input int from_code);
      work_drained = 1'b1;
      tick(1);
      work_drained = 1'b0;
      for (int k = 1; k <= DRAIN_N; k++) begin
         if (k > 1) tick(1);
         state_is(req, (k == DRAIN_N) ? S_STOP : from_code);
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] d;
      logic [63:0] exp_cap0, exp_cap1;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      state_is("R1 state", S_STOP);
      peek(A_CTL0, d); chk("R1 ctl0", d, 64'd0);
      peek(A_LIM, d);  chk("R1 limits", d, 64'd0);

      // R10 R11 R12 constant registers
      exp_cap0 = 64'(SUBFN) | (64'(DBX) << 20) | (64'(RING) << 24);
      exp_cap1 = 64'(MBUF) | (64'(MKEY) << 12) | (64'(MCTX) << 16) | (64'(MOPG) << 32);
      peek(A_CAP0, d); chk("R11 cap0", d, exp_cap0);
      chk("R11 stride", 64'(db_stride_bytes), 64'(4096) << DBX);
      peek(A_CAP1, d); chk("R10 cap1", d, exp_cap1);
      peek(A_VER, d);  chk("R12 version", d, 64'h1_0000);

      // R13 writes to read-only and unmapped addresses
      wr(A_CAP0, '1); wr(A_CAP1, '1); wr(A_VER, '1); wr(A_STS, '1); wr(12'h008, '1);
      peek(A_CAP0, d); chk("R13 cap0 kept", d, exp_cap0);
      peek(A_CAP1, d); chk("R13 cap1 kept", d, exp_cap1);
      peek(A_VER, d);  chk("R13 ver kept", d, 64'h1_0000);
      peek(12'h008, d); chk("R13 unmapped", d, 64'd0);
      peek(12'h300, d); chk("R13 unmapped hi", d, 64'd0);
      peek(A_LIM, d);  chk("R13 limits kept", d, 64'd0);
      state_is("R13 state kept", S_STOP);

      // R4 R7 illegal commands in stopped; R2 readback
      wr(A_CTL0, C_SOFT); state_is("R4 soft in stopped", S_STOP);
      wr(A_CTL0, C_HARD); state_is("R4 hard in stopped", S_STOP);
      peek(A_CTL0, d); chk("R2 ctl0 readback", d, 64'd2);
      wr(A_CTL0, C_RST); state_is("R4 reset in stopped", S_STOP);

      // R6 fault in stopped ignored
      fn_fault = 1'b1; tick(1); fn_fault = 1'b0;
      state_is("R6 fault in stopped", S_STOP);

      // R3 activate timing sweep
      wr(A_CTL0, C_ACT);
      state_is("R3 enter init", S_INIT);
      for (int k = 1; k <= INIT_N; k++) begin
         tick(1);
         state_is("R3 init timing", (k == INIT_N) ? S_ACT : S_INIT);
      end
      wr(A_CTL0, C_ACT);  state_is("R3 activate in active", S_ACT);
      wr(A_CTL0, C_HARD); state_is("R4 hard in active", S_ACT);
      wr(A_CTL0, C_RST);  state_is("R4 reset in active", S_ACT);

      // R2 upper ctl0 bits ignored; soft stop
      wr(A_CTL0, 64'hFFFF_FFFF_FFFF_FFFD);
      state_is("R4 soft from active", S_SOFT);
      peek(A_CTL0, d); chk("R2 ctl0 field only", d, 64'd1);
      wr(A_CTL0, C_ACT);  state_is("R3 activate in soft", S_SOFT);
      tick(6); state_is("R5 no drain holds", S_SOFT);
      drain_sweep("R5 soft drain", S_SOFT);

      // R4 R5 escalation restarts wait
      go_active();
      wr(A_CTL0, C_SOFT);
      work_drained = 1'b1; tick(1); work_drained = 1'b0;
      wr(A_CTL0, C_HARD);
      state_is("R4 hard from soft", S_HARD);
      tick(6); state_is("R5 hard restart", S_HARD);
      drain_sweep("R5 hard drain", S_HARD);

      // R8 hard stop on the drain completing edge
      go_active();
      wr(A_CTL0, C_SOFT);
      work_drained = 1'b1; tick(1); work_drained = 1'b0;
      tick(DRAIN_N - 2);
      wr(A_CTL0, C_HARD);
      state_is("R8 drain beats hard", S_STOP);

      // R8 soft stop on the init completing edge
      wr(A_CTL0, C_ACT);
      tick(INIT_N - 1);
      wr(A_CTL0, C_SOFT);
      state_is("R8 init beats soft", S_ACT);
      wr(A_CTL0, C_SOFT); state_is("R4 soft from active", S_SOFT);
      drain_sweep("R5 drain again", S_SOFT);

      // R6 fault with a legal command, R7 error exits
      wr(A_CTL0, C_ACT);
      wr(A_CTL0, C_SOFT, 1'b1);
      state_is("R6 fault beats command", S_ERR);
      wr(A_CTL0, C_ACT);  state_is("R7 activate in error", S_ERR);
      wr(A_CTL0, C_SOFT); state_is("R7 soft in error", S_ERR);
      wr(A_CTL0, C_HARD); state_is("R7 hard in error", S_ERR);
      fn_fault = 1'b1; tick(1); fn_fault = 1'b0;
      state_is("R6 fault in error", S_ERR);
      wr(A_CTL0, C_RST);  state_is("R7 reset leaves error", S_STOP);

      go_active();
      fn_fault = 1'b1; tick(1); fn_fault = 1'b0;
      state_is("R6 fault in active", S_ERR);
      wr(A_CTL0, C_RST); state_is("R7 reset again", S_STOP);

      // R6 fault beats drain completion
      go_active();
      wr(A_CTL0, C_SOFT);
      work_drained = 1'b1; tick(1); work_drained = 1'b0;
      tick(DRAIN_N - 2);
      fn_fault = 1'b1; tick(1); fn_fault = 1'b0;
      state_is("R6 fault beats drain", S_ERR);
      wr(A_CTL0, C_RST); state_is("R7 reset final", S_STOP);

      // R9 limits clamp sweep
      for (int v = 0; v < 16; v++) begin
         logic [3:0]  nb;
         logic [15:0] nc;
         logic [31:0] nm;
         logic [63:0] w, e;
         nb = 4'(v);
         nc = 16'(v * 37);
         nm = {8{nb}};
         w  = {nm, nc, nb, 8'hA5, nb};
         e  = {nm & MOPG, (nc > MCTX) ? MCTX : nc, (nb > MKEY) ? MKEY : nb, 8'h00,
               (nb > MBUF) ? MBUF : nb};
         wr(A_LIM, w);
         peek(A_LIM, d);
         chk("R9 limits clamp", d, e);
      end
      wr(A_LIM, '1);
      peek(A_LIM, d); chk("R9 all ones", d, exp_cap1);
      state_is("R9 state untouched", S_STOP);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule